// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the operand field of a decoded instruction into the 16-bit byte address of a memory operand. It takes a three-bit addressing-mode code, a one-bit base selector, the current values of the two address registers, the static base, the frame base and both stack pointers, and a 16-bit field from the instruction. That field holds either an absolute address or a displacement. The address space is 64 KB and byte addressed. Every sum wraps modulo 2^16.

Some modes name no memory location: the operand is an immediate value or sits in the register file. For these modes the block raises a source flag and holds the address at zero. The memory-operand valid flag is raised only when the address output is meaningful. The operand size bit passes straight through for the memory stage that follows.

The block is purely combinational and holds no state. It has three pieces:
- a mode decoder that picks the base and the kind of displacement;
- a base multiplexer that also chooses the stack pointer bank;
- a displacement extender.

A single adder joins the base and the extended displacement.

Top module: `eag_top`

## Requirements
- R1: With mode 2 (absolute), `ea_addr` equals `disp`, `mem_valid` is 1, and `src_imm` and `src_reg` are 0.
- R2: With mode 3 (indirect), `ea_addr` equals A0 when `base_sel`=0 and A1 when `base_sel`=1, whatever the value of `disp`.
- R3: With mode 4 (register relative), `ea_addr` equals A0 (`base_sel`=0) or A1 (`base_sel`=1) plus the full 16-bit `disp` taken as unsigned, modulo 2^16.
- R4: With mode 5 (static-base relative), `ea_addr` equals SB plus the unsigned 16-bit `disp`, modulo 2^16. `base_sel` has no effect.
- R5: With mode 6 (stack relative), `ea_addr` equals FB (`base_sel`=0) or the stack pointer (`base_sel`=1) plus `disp[7:0]` sign-extended to 16 bits, modulo 2^16. `disp[15:8]` has no effect.
- R6: In mode 6 with `base_sel`=1, the stack pointer used is `usp` when `sp_bank`=0 and `isp` when `sp_bank`=1. `sp_bank` has no effect in any other mode.
- R7: With mode 0 (immediate), `src_imm`=1, `mem_valid`=0, `src_reg`=0 and `ea_addr`=0.
- R8: With mode 1 (register direct), `src_reg`=1, `mem_valid`=0, `src_imm`=0 and `ea_addr`=0.
- R9: Mode 7 is reserved. It drives all three flags to 0 and `ea_addr` to 0.
- R10: `size_out` always equals `size_in` (1 = word, 0 = byte), in every mode.
- R11: At most one of `mem_valid`, `src_imm` and `src_reg` is 1 at any time. Exactly one is 1 for modes 0 to 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 3 | Addressing-mode code (0 imm, 1 reg, 2 abs, 3 ind, 4 rel, 5 sb, 6 stack, 7 reserved) |
| base_sel | input | 1 | Base choice: A0/A1 in modes 3-4, FB/SP in mode 6 |
| sp_bank | input | 1 | Stack pointer bank: 0 user, 1 interrupt |
| reg_a0 | input | 16 | Address register 0 |
| reg_a1 | input | 16 | Address register 1 |
| reg_sb | input | 16 | Static base register |
| reg_fb | input | 16 | Frame base register |
| reg_usp | input | 16 | User stack pointer |
| reg_isp | input | 16 | Interrupt stack pointer |
| disp | input | 16 | Absolute address or displacement from the instruction |
| size_in | input | 1 | Operand size, 1 word / 0 byte |
| ea_addr | output | 16 | Effective byte address, 0 when no memory operand |
| mem_valid | output | 1 | Operand is in memory at `ea_addr` |
| src_imm | output | 1 | Operand comes from the instruction |
| src_reg | output | 1 | Operand comes from the register file |
| size_out | output | 1 | Copy of `size_in` |

## Verification
The bench builds the block with its defaults: a 16-bit address and an 8-bit short displacement. At that size, random register values regularly carry the sums across FFFFH. Random 16-bit `disp` values give sign-extended short offsets of both polarities. The bench also includes the exact -128 and +127 limits.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [2:0] {
        MODE_IMM = 3'd0,
        MODE_REG = 3'd1,
        MODE_ABS = 3'd2,
        MODE_IND = 3'd3,
        MODE_REL = 3'd4,
        MODE_SBR = 3'd5,
        MODE_STK = 3'd6,
        MODE_RSV = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        BASE_ZERO,
        BASE_A0,
        BASE_A1,
        BASE_SB,
        BASE_FB,
        BASE_SP
    } base_e;

    typedef enum logic [1:0] {
        DISP_NONE,
        DISP_FULL,
        DISP_SHORT
    } disp_e;

endpackage

// File: rtl/eag_mode_decode.sv
module eag_mode_decode
    import eag_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       base_sel,
    output base_e      base_kind,
    output disp_e      disp_kind,
    output logic       mem_valid,
    output logic       src_imm,
    output logic       src_reg
);

    mode_e mode_q;
    assign mode_q = mode_e'(mode);

    always_comb begin
        base_kind = BASE_ZERO;
        disp_kind = DISP_NONE;
        mem_valid = 1'b0;
        src_imm   = 1'b0;
        src_reg   = 1'b0;
        unique case (mode_q)
            MODE_IMM: src_imm = 1'b1;
            MODE_REG: src_reg = 1'b1;
            MODE_ABS: begin
                disp_kind = DISP_FULL;
                mem_valid = 1'b1;
            end
            MODE_IND: begin
                base_kind = base_sel ? BASE_A1 : BASE_A0;
                mem_valid = 1'b1;
            end
            MODE_REL: begin
                base_kind = base_sel ? BASE_A1 : BASE_A0;
                disp_kind = DISP_FULL;
                mem_valid = 1'b1;
            end
            MODE_SBR: begin
                base_kind = BASE_SB;
                disp_kind = DISP_FULL;
                mem_valid = 1'b1;
            end
            MODE_STK: begin
                base_kind = base_sel ? BASE_SP : BASE_FB;
                disp_kind = DISP_SHORT;
                mem_valid = 1'b1;
            end
            MODE_RSV: begin
                mem_valid = 1'b0;
            end
        endcase
    end

    // R11: source flags never overlap
    always_comb begin
        a_r11_one_source: assert ($countones({mem_valid, src_imm, src_reg}) <= 1)
            else $error("R11: more than one operand source flagged");
    end

endmodule

// File: rtl/eag_base_mux.sv
module eag_base_mux
    import eag_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  base_e              base_kind,
    input  logic               sp_bank,
    input  logic [ADDR_W-1:0]  reg_a0,
    input  logic [ADDR_W-1:0]  reg_a1,
    input  logic [ADDR_W-1:0]  reg_sb,
    input  logic [ADDR_W-1:0]  reg_fb,
    input  logic [ADDR_W-1:0]  reg_usp,
    input  logic [ADDR_W-1:0]  reg_isp,
    output logic [ADDR_W-1:0]  base_val
);

    logic [ADDR_W-1:0] live_sp;
    assign live_sp = sp_bank ? reg_isp : reg_usp;

    always_comb begin
        unique case (base_kind)
            BASE_A0: base_val = reg_a0;
            BASE_A1: base_val = reg_a1;
            BASE_SB: base_val = reg_sb;
            BASE_FB: base_val = reg_fb;
            BASE_SP: base_val = live_sp;
            default: base_val = '0;
        endcase
    end

endmodule

// File: rtl/eag_disp_ext.sv
module eag_disp_ext
    import eag_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SHORT_W = 8
) (
    input  disp_e             disp_kind,
    input  logic [ADDR_W-1:0] disp,
    output logic [ADDR_W-1:0] disp_ext
);

    localparam int PAD_W = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] short_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign short_ext = {{PAD_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        end else begin : g_nopad
            assign short_ext = disp;
        end
    endgenerate

    always_comb begin
        unique case (disp_kind)
            DISP_FULL:  disp_ext = disp;
            DISP_SHORT: disp_ext = short_ext;
            default:    disp_ext = '0;
        endcase
    end

endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic [2:0]        mode,
    input  logic              base_sel,
    input  logic              sp_bank,
    input  logic [ADDR_W-1:0] reg_a0,
    input  logic [ADDR_W-1:0] reg_a1,
    input  logic [ADDR_W-1:0] reg_sb,
    input  logic [ADDR_W-1:0] reg_fb,
    input  logic [ADDR_W-1:0] reg_usp,
    input  logic [ADDR_W-1:0] reg_isp,
    input  logic [ADDR_W-1:0] disp,
    input  logic              size_in,
    output logic [ADDR_W-1:0] ea_addr,
    output logic              mem_valid,
    output logic              src_imm,
    output logic              src_reg,
    output logic              size_out
);

    localparam logic [ADDR_W-1:0] POS_LIM = ADDR_W'((1 << (SHORT_W - 1)) - 1);
    localparam logic [ADDR_W-1:0] NEG_LIM = ~POS_LIM;

    base_e             base_kind;
    disp_e             disp_kind;
    logic [ADDR_W-1:0] base_val;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] offset;

    eag_mode_decode u_dec (
        .mode      (mode),
        .base_sel  (base_sel),
        .base_kind (base_kind),
        .disp_kind (disp_kind),
        .mem_valid (mem_valid),
        .src_imm   (src_imm),
        .src_reg   (src_reg)
    );

    eag_base_mux #(.ADDR_W(ADDR_W)) u_base (
        .base_kind (base_kind),
        .sp_bank   (sp_bank),
        .reg_a0    (reg_a0),
        .reg_a1    (reg_a1),
        .reg_sb    (reg_sb),
        .reg_fb    (reg_fb),
        .reg_usp   (reg_usp),
        .reg_isp   (reg_isp),
        .base_val  (base_val)
    );

    eag_disp_ext #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_disp (
        .disp_kind (disp_kind),
        .disp      (disp),
        .disp_ext  (disp_ext)
    );

    assign ea_addr  = base_val + disp_ext;
    assign size_out = size_in;
    assign offset   = ea_addr - base_val;

    always_comb begin
        // R1: absolute address is the instruction field itself
        if (mode == 3'd2)
            a_r1_abs_field: assert (ea_addr == disp) else $error("R1: absolute address mismatch");
        // R2: indirect address equals the chosen base register
        if (mode == 3'd3)
            a_r2_ind_base: assert (ea_addr == (base_sel ? reg_a1 : reg_a0))
                else $error("R2: indirect address mismatch");
        // R5: stack-relative offset stays within the short signed range
        if (mode == 3'd6)
            a_r5_short_range: assert (offset <= POS_LIM || offset >= NEG_LIM)
                else $error("R5: stack offset out of range");
        // R7/R8/R9: no memory operand means address zero
        if (!mem_valid)
            a_r9_zero_addr: assert (ea_addr == '0) else $error("R9: address not zero");
    end

endmodule

// File: tb/tb_eag_top.sv
module tb_eag_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]  mode;
    logic        base_sel, sp_bank, size_in;
    logic [15:0] reg_a0, reg_a1, reg_sb, reg_fb, reg_usp, reg_isp, disp;
    logic [15:0] ea_addr;
    logic        mem_valid, src_imm, src_reg, size_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic done = 1'b0;

    eag_top dut (
        .mode(mode), .base_sel(base_sel), .sp_bank(sp_bank),
        .reg_a0(reg_a0), .reg_a1(reg_a1), .reg_sb(reg_sb), .reg_fb(reg_fb),
        .reg_usp(reg_usp), .reg_isp(reg_isp), .disp(disp), .size_in(size_in),
        .ea_addr(ea_addr), .mem_valid(mem_valid), .src_imm(src_imm),
        .src_reg(src_reg), .size_out(size_out)
    );

    function automatic logic [15:0] exp_addr();
        logic [15:0] sx;
        sx = {{8{disp[7]}}, disp[7:0]};
        case (mode)
            3'd2: return disp;
            3'd3: return base_sel ? reg_a1 : reg_a0;
            3'd4: return (base_sel ? reg_a1 : reg_a0) + disp;
            3'd5: return reg_sb + disp;
            3'd6: return (base_sel ? (sp_bank ? reg_isp : reg_usp) : reg_fb) + sx;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string req_of();
        case (mode)
            3'd0: return "R7";
            3'd1: return "R8";
            3'd2: return "R1";
            3'd3: return "R2";
            3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (mode %0d)", req, act, exp, mode);
        end
    endtask

    task automatic check_all();
        logic ev;
        @(negedge clk);
        #1;
        ev = (mode >= 3'd2 && mode <= 3'd6);
        cmp(req_of(), {16'h0, ea_addr}, {16'h0, exp_addr()});
        cmp("R11", {29'h0, mem_valid, src_imm, src_reg},
            {29'h0, ev, mode == 3'd0, mode == 3'd1});
        cmp("R10", {31'h0, size_out}, {31'h0, size_in});
    endtask

    task automatic setregs(input logic [15:0] a0, input logic [15:0] a1, input logic [15:0] sb,
                           input logic [15:0] fb, input logic [15:0] us, input logic [15:0] is);
        reg_a0 = a0; reg_a1 = a1; reg_sb = sb; reg_fb = fb; reg_usp = us; reg_isp = is;
    endtask

    task automatic apply(input logic [2:0] m, input logic bs, input logic bk, input logic [15:0] d);
        @(posedge clk);
        mode = m; base_sel = bs; sp_bank = bk; disp = d; size_in = ~size_in;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        mode = 3'd0; base_sel = 1'b0; sp_bank = 1'b0; size_in = 1'b0; disp = 16'h0;
        setregs(16'h81A6, 16'h1110, 16'h150E, 16'h2000, 16'h1514, 16'h3000);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: mode 0 gives immediate flag only (R7)
        check_all();

        // R3 directed: A1=1110H + 4
        apply(3'd4, 1'b1, 1'b0, 16'h0004); check_all();
        cmp("R3", {16'h0, ea_addr}, 32'h1114);
        // R4 directed: SB=150EH + 2, base_sel ignored
        apply(3'd5, 1'b1, 1'b1, 16'h0002); check_all();
        cmp("R4", {16'h0, ea_addr}, 32'h1510);
        // R5 directed: SP=1514H - 6, upper disp bits ignored
        apply(3'd6, 1'b1, 1'b0, 16'hABFA); check_all();
        cmp("R5", {16'h0, ea_addr}, 32'h150E);
        // R5 limits -128 and +127 from FB
        apply(3'd6, 1'b0, 1'b0, 16'h0080); check_all();
        cmp("R5", {16'h0, ea_addr}, 32'h1F80);
        apply(3'd6, 1'b0, 1'b1, 16'hFF7F); check_all();
        cmp("R5", {16'h0, ea_addr}, 32'h207F);
        // R6: interrupt bank picks ISP
        apply(3'd6, 1'b1, 1'b1, 16'h0010); check_all();
        cmp("R6", {16'h0, ea_addr}, 32'h3010);
        // R6: bank ignored outside stack mode
        apply(3'd3, 1'b0, 1'b1, 16'h1234); check_all();
        cmp("R6", {16'h0, ea_addr}, 32'h81A6);
        // R2: A1 indirect, displacement ignored
        apply(3'd3, 1'b1, 1'b0, 16'hFFFF); check_all();
        cmp("R2", {16'h0, ea_addr}, 32'h1110);
        // R3 wrap: A0=FFF0H + 0020H
        setregs(16'hFFF0, 16'h1110, 16'hFFFF, 16'h0005, 16'h1514, 16'h3000);
        apply(3'd4, 1'b0, 1'b0, 16'h0020); check_all();
        cmp("R3", {16'h0, ea_addr}, 32'h0010);
        // R4 wrap: SB=FFFFH + FFFFH
        apply(3'd5, 1'b0, 1'b0, 16'hFFFF); check_all();
        cmp("R4", {16'h0, ea_addr}, 32'hFFFE);
        // R5 wrap below zero: FB=0005H - 6
        apply(3'd6, 1'b0, 1'b0, 16'h00FA); check_all();
        cmp("R5", {16'h0, ea_addr}, 32'hFFFF);
        // R1, R8, R9 directed
        apply(3'd2, 1'b1, 1'b1, 16'h213A); check_all();
        cmp("R1", {16'h0, ea_addr}, 32'h213A);
        apply(3'd1, 1'b1, 1'b1, 16'hBEEF); check_all();
        cmp("R8", {31'h0, src_reg}, 32'h1);
        apply(3'd7, 1'b1, 1'b1, 16'hBEEF); check_all();
        cmp("R9", {29'h0, mem_valid, src_imm, src_reg}, 32'h0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            setregs(16'($urandom), 16'($urandom), 16'($urandom),
                    16'($urandom), 16'($urandom), 16'($urandom));
            apply(3'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
            check_all();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule